// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two clock domains, port A and port B, with two independent first-in first-out queues that run in opposite directions. The forward queue takes words written at port A and delivers them at port B. The return queue takes words written at port B and delivers them at port A. Each queue holds 64 words of 36 bits by default. Each queue keeps its write and read positions as gray-coded counters. Each counter crosses into the opposite domain through a chain of flops.

Each port has four controls: an active-low select, a direction bit (1 = write, 0 = read), a mailbox bit and an enable. Together they pick one access per cycle: a write into the queue that the port feeds, or a read from the queue that the port drains. When the mailbox bit is high the port makes no queue access. Four active-low level flags report how full the queues are, each in the clock of the port that uses it. The offset X that sets the flag thresholds is a parameter.

Top module: `bidir_fifo_pair`

## Requirements
- R1: While the resets are held and right after they are released, both almost-empty flags are low and both almost-full flags are high.
- R2: Words written at port A arrive at port B unchanged and in write order, also while writes and reads overlap.
- R3: Words written at port B arrive at port A unchanged and in write order.
- R4: A port writes on a rising edge of its own clock only when select is 0, direction is 1, mailbox is 0 and enable is 1. It reads only with direction 0 under the same other conditions. With mailbox 1, select 1 or enable 0 the port makes no access, so no word is queued and the read data does not change.
- R5: The port-A almost-empty flag of the return queue is low while that queue holds X or fewer words and high once it holds X+1 or more (X defaults to 8).
- R6: The port-A almost-full flag of the forward queue is low while that queue holds DEPTH-X or more words and high at DEPTH-X-1 or fewer.
- R7: The port-B almost-full flag of the return queue follows the rule of R6. The port-B almost-empty flag of the forward queue follows the rule of R5.
- R8: A flag is driven low by an access on its own port, and it is already low after the next edge of that port's clock.
- R9: When an access on the other port releases a flag, the flag goes high after the second rising edge of its own clock that follows that access. It goes high one edge later when the two clock edges nearly coincide.
- R10: A write to a full queue is dropped. The write position does not move, and the words already stored come out intact.
- R11: A read from an empty queue is dropped. The read data keeps its last value and the read position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| cs_a_n | input | 1 | Port A select, active low |
| wr_a | input | 1 | Port A direction: 1 write, 0 read |
| mbox_a | input | 1 | Port A mailbox select; 1 blocks queue access |
| en_a | input | 1 | Port A access enable |
| din_a | input | DATA_W | Write data into the forward queue |
| dout_a | output | DATA_W | Read data from the return queue |
| a_f2_aempty_n | output | 1 | Return queue almost empty, clock A, active low |
| a_f1_afull_n | output | 1 | Forward queue almost full, clock A, active low |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| cs_b_n | input | 1 | Port B select, active low |
| wr_b | input | 1 | Port B direction: 1 write, 0 read |
| mbox_b | input | 1 | Port B mailbox select; 1 blocks queue access |
| en_b | input | 1 | Port B access enable |
| din_b | input | DATA_W | Write data into the return queue |
| dout_b | output | DATA_W | Read data from the forward queue |
| b_f1_aempty_n | output | 1 | Forward queue almost empty, clock B, active low |
| b_f2_afull_n | output | 1 | Return queue almost full, clock B, active low |

## Verification
Two things can land in the same port-A cycle: a local write that raises the count of the forward queue, and a synchronized read position from port B that lowers it. A streaming test writes a burst at port A while port B drains the same queue with only a few cycles of lag. The test is judged by the order of the delivered words. The flag-release test reads a single word at port B against a queue that sits at the almost-full level. It then counts port-A edges until the flag rises. The clock periods are chosen so that no edges coincide, so exactly two edges are expected.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

   // Access chosen by one port in one cycle
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_READ  = 2'd2
   } acc_e;

endpackage

// File: rtl/bfp_port_decode.sv
module bfp_port_decode
   import bfp_pkg::*;
(
   input  logic sel_n,
   input  logic dir_wr,
   input  logic mbox,
   input  logic en,
   output acc_e acc
);

   always_comb begin
      acc = ACC_IDLE;
      if (!sel_n && !mbox && en) begin
         acc = dir_wr ? ACC_WRITE : ACC_READ;
      end
   end

endmodule

// File: rtl/bfp_gray_sync.sv
module bfp_gray_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bfp_gray_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] q_r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= g_stage[g-1].q_r;
         end
      end
   end

   assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/bfp_lane.sv
module bfp_lane #(
   parameter int DATA_W      = 36,
   parameter int DEPTH       = 64,
   parameter int ALMOST_OFS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_afull_n,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_aempty_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   typedef logic [PW-1:0] ptr_t;
   localparam ptr_t FULL_CNT = ptr_t'(DEPTH);
   localparam ptr_t AF_LVL   = ptr_t'(DEPTH - ALMOST_OFS);
   localparam ptr_t AE_LVL   = ptr_t'(ALMOST_OFS);

   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("bfp_lane: DEPTH must be a power of two");
   end
   if (ALMOST_OFS < 1 || ALMOST_OFS >= DEPTH / 2) begin : g_bad_ofs
      $error("bfp_lane: ALMOST_OFS must lie in 1 .. DEPTH/2-1");
   end

   function automatic ptr_t bin2gray(input ptr_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic ptr_t gray2bin(input ptr_t g);
      ptr_t b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DATA_W-1:0] mem [DEPTH];

   ptr_t wbin, wgray, rgray_s, rbin_s, wcount;
   ptr_t rbin, rgray, wgray_s, wbin_s, rcount;
   logic full, wr_acc, empty, rd_acc;

   // ---------------- write domain ----------------
   bfp_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk   (wclk),
      .rst_n (wrst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   always_comb begin
      rbin_s     = gray2bin(rgray_s);
      wcount     = wbin - rbin_s;
      full       = (wcount == FULL_CNT);
      wr_acc     = wr_req && !full;
      wr_afull_n = (wcount < AF_LVL);
   end

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_acc) begin
         wbin  <= wbin + ptr_t'(1);
         wgray <= bin2gray(wbin + ptr_t'(1));
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_acc) mem[wbin[AW-1:0]] <= wdata;
   end

   // ---------------- read domain ----------------
   bfp_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk   (rclk),
      .rst_n (rrst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   always_comb begin
      wbin_s      = gray2bin(wgray_s);
      rcount      = wbin_s - rbin;
      empty       = (rcount == '0);
      rd_acc      = rd_req && !empty;
      rd_aempty_n = (rcount > AE_LVL);
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
         rdata <= '0;
      end else if (rd_acc) begin
         rbin  <= rbin + ptr_t'(1);
         rgray <= bin2gray(rbin + ptr_t'(1));
         rdata <= mem[rbin[AW-1:0]];
      end
   end

   // ---------------- assertions ----------------
   assert_gray_step_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
      $onehot0(wgray ^ $past(wgray)));

   assert_no_overflow_R10: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wr_req && full) |=> (wbin == $past(wbin)));

   assert_no_underflow_R11: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rd_req && empty) |=> (rbin == $past(rbin) && rdata == $past(rdata)));

   assert_count_bound_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
      wcount <= FULL_CNT);

   assert_afull_own_port_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
      $fell(wr_afull_n) |-> $past(wr_acc));

   assert_aempty_own_port_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
      $fell(rd_aempty_n) |-> $past(rd_acc));

endmodule

// File: rtl/bidir_fifo_pair.sv
module bidir_fifo_pair
   import bfp_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int DEPTH       = 64,
   parameter int ALMOST_OFS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_a,
   input  logic              rst_a_n,
   input  logic              cs_a_n,
   input  logic              wr_a,
   input  logic              mbox_a,
   input  logic              en_a,
   input  logic [DATA_W-1:0] din_a,
   output logic [DATA_W-1:0] dout_a,
   output logic              a_f2_aempty_n,
   output logic              a_f1_afull_n,
   input  logic              clk_b,
   input  logic              rst_b_n,
   input  logic              cs_b_n,
   input  logic              wr_b,
   input  logic              mbox_b,
   input  logic              en_b,
   input  logic [DATA_W-1:0] din_b,
   output logic [DATA_W-1:0] dout_b,
   output logic              b_f1_aempty_n,
   output logic              b_f2_afull_n
);

   acc_e acc_a, acc_b;

   bfp_port_decode u_dec_a (
      .sel_n  (cs_a_n),
      .dir_wr (wr_a),
      .mbox   (mbox_a),
      .en     (en_a),
      .acc    (acc_a)
   );

   bfp_port_decode u_dec_b (
      .sel_n  (cs_b_n),
      .dir_wr (wr_b),
      .mbox   (mbox_b),
      .en     (en_b),
      .acc    (acc_b)
   );

   // Forward queue: port A writes, port B reads
   bfp_lane #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .ALMOST_OFS(ALMOST_OFS), .SYNC_STAGES(SYNC_STAGES)
   ) u_fwd (
      .wclk        (clk_a),
      .wrst_n      (rst_a_n),
      .wr_req      (acc_a == ACC_WRITE),
      .wdata       (din_a),
      .wr_afull_n  (a_f1_afull_n),
      .rclk        (clk_b),
      .rrst_n      (rst_b_n),
      .rd_req      (acc_b == ACC_READ),
      .rdata       (dout_b),
      .rd_aempty_n (b_f1_aempty_n)
   );

   // Return queue: port B writes, port A reads
   bfp_lane #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .ALMOST_OFS(ALMOST_OFS), .SYNC_STAGES(SYNC_STAGES)
   ) u_ret (
      .wclk        (clk_b),
      .wrst_n      (rst_b_n),
      .wr_req      (acc_b == ACC_WRITE),
      .wdata       (din_b),
      .wr_afull_n  (b_f2_afull_n),
      .rclk        (clk_a),
      .rrst_n      (rst_a_n),
      .rd_req      (acc_a == ACC_READ),
      .rdata       (dout_a),
      .rd_aempty_n (a_f2_aempty_n)
   );

endmodule

// File: tb/test_bidir_fifo_pair.sv
module test_bidir_fifo_pair;

   localparam int DW    = 36;
   localparam int DEPTH = 64;
   localparam int X     = 8;

   logic          clk_a = 1'b0, clk_b = 1'b0;
   logic          rst_a_n = 1'b0, rst_b_n = 1'b0;
   logic          cs_a_n = 1'b1, wr_a = 1'b0, mbox_a = 1'b0, en_a = 1'b0;
   logic          cs_b_n = 1'b1, wr_b = 1'b0, mbox_b = 1'b0, en_b = 1'b0;
   logic [DW-1:0] din_a = '0, din_b = '0;
   logic [DW-1:0] dout_a, dout_b;
   logic          a_f2_aempty_n, a_f1_afull_n, b_f1_aempty_n, b_f2_afull_n;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] q1[$];
   logic [DW-1:0] q2[$];

   always #5 clk_a = ~clk_a;
   always #8 clk_b = ~clk_b;

   bidir_fifo_pair #(.DATA_W(DW), .DEPTH(DEPTH), .ALMOST_OFS(X)) i_bidir_fifo_pair (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .cs_a_n(cs_a_n), .wr_a(wr_a), .mbox_a(mbox_a),
      .en_a(en_a), .din_a(din_a), .dout_a(dout_a), .a_f2_aempty_n(a_f2_aempty_n),
      .a_f1_afull_n(a_f1_afull_n),
      .clk_b(clk_b), .rst_b_n(rst_b_n), .cs_b_n(cs_b_n), .wr_b(wr_b), .mbox_b(mbox_b),
      .en_b(en_b), .din_b(din_b), .dout_b(dout_b), .b_f1_aempty_n(b_f1_aempty_n),
      .b_f2_afull_n(b_f2_afull_n)
   );

   function automatic logic [DW-1:0] pat(input int s);
      logic [31:0] v;
      v = 32'(s) * 32'h9E37_79B1 + 32'h1357_0000;
      return {v[3:0] ^ 4'h5, v};
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic idle_a();
      cs_a_n = 1'b1; wr_a = 1'b0; mbox_a = 1'b0; en_a = 1'b0;
   endtask

   task automatic idle_b();
      cs_b_n = 1'b1; wr_b = 1'b0; mbox_b = 1'b0; en_b = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(negedge clk_b);
   endtask

   task automatic push_a(input int n, input int seed);
      @(negedge clk_a);
      cs_a_n = 1'b0; wr_a = 1'b1; mbox_a = 1'b0; en_a = 1'b1;
      for (int i = 0; i < n; i++) begin
         din_a = pat(seed + i);
         if (q1.size() < DEPTH) q1.push_back(din_a);
         @(negedge clk_a);
      end
      idle_a();
   endtask

   task automatic push_b(input int n, input int seed);
      @(negedge clk_b);
      cs_b_n = 1'b0; wr_b = 1'b1; mbox_b = 1'b0; en_b = 1'b1;
      for (int i = 0; i < n; i++) begin
         din_b = pat(seed + i);
         if (q2.size() < DEPTH) q2.push_back(din_b);
         @(negedge clk_b);
      end
      idle_b();
   endtask

   task automatic pop_b(input int n, input string req);
      @(negedge clk_b);
      cs_b_n = 1'b0; wr_b = 1'b0; mbox_b = 1'b0; en_b = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk_b);
         chk(req, dout_b, (q1.size() > 0) ? q1.pop_front() : 'x);
      end
      idle_b();
   endtask

   task automatic pop_a(input int n, input string req);
      @(negedge clk_a);
      cs_a_n = 1'b0; wr_a = 1'b0; mbox_a = 1'b0; en_a = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk_a);
         chk(req, dout_a, (q2.size() > 0) ? q2.pop_front() : 'x);
      end
      idle_a();
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 reset a_f2_aempty_n", DW'(a_f2_aempty_n), DW'(0));
      chk("R1 reset a_f1_afull_n",  DW'(a_f1_afull_n),  DW'(1));
      chk("R1 reset b_f1_aempty_n", DW'(b_f1_aempty_n), DW'(0));
      chk("R1 reset b_f2_afull_n",  DW'(b_f2_afull_n),  DW'(1));
   endtask

   task automatic t_fwd_basic();
      push_a(5, 100);
      settle();
      pop_b(5, "R2 A-to-B order");
   endtask

   task automatic t_ret_basic();
      push_b(5, 200);
      settle();
      pop_a(5, "R3 B-to-A order");
   endtask

   task automatic t_stream();
      fork
         push_a(20, 300);
         begin
            repeat (6) @(negedge clk_a);
            pop_b(20, "R2 overlapped stream");
         end
      join
      settle();
   endtask

   task automatic t_decode();
      logic [DW-1:0] held;
      // blocked writes: mailbox, deselected, disabled
      @(negedge clk_a);
      cs_a_n = 1'b0; wr_a = 1'b1; mbox_a = 1'b1; en_a = 1'b1; din_a = pat(999);
      repeat (3) @(negedge clk_a);
      mbox_a = 1'b0; cs_a_n = 1'b1;
      @(negedge clk_a);
      cs_a_n = 1'b0; en_a = 1'b0;
      @(negedge clk_a);
      idle_a();
      push_a(1, 400);
      settle();
      chk("R4 blocked writes leave level", DW'(b_f1_aempty_n), DW'(0));
      // blocked read with mailbox high
      held = dout_b;
      @(negedge clk_b);
      cs_b_n = 1'b0; wr_b = 1'b0; mbox_b = 1'b1; en_b = 1'b1;
      repeat (3) @(negedge clk_b);
      chk("R4 mailbox read keeps dout_b", dout_b, held);
      idle_b();
      pop_b(1, "R4 only the decoded write was queued");
   endtask

   task automatic t_aempty();
      push_b(X, 500);
      settle();
      chk("R5 a_f2_aempty_n at X words", DW'(a_f2_aempty_n), DW'(0));
      push_b(1, 500 + X);
      settle();
      chk("R5 a_f2_aempty_n at X+1 words", DW'(a_f2_aempty_n), DW'(1));
      pop_a(1, "R3 return data");
      chk("R8 a_f2_aempty_n low after own read", DW'(a_f2_aempty_n), DW'(0));
      pop_a(X, "R3 return data");
      push_a(X + 1, 600);
      settle();
      chk("R7 b_f1_aempty_n at X+1 words", DW'(b_f1_aempty_n), DW'(1));
      pop_b(1, "R2 forward data");
      chk("R7 b_f1_aempty_n at X words", DW'(b_f1_aempty_n), DW'(0));
      pop_b(X, "R2 forward data");
      settle();
   endtask

   task automatic t_afull_b();
      push_b(DEPTH - X - 1, 700);
      settle();
      chk("R7 b_f2_afull_n at DEPTH-X-1", DW'(b_f2_afull_n), DW'(1));
      push_b(1, 700 + DEPTH);
      chk("R7/R8 b_f2_afull_n at DEPTH-X", DW'(b_f2_afull_n), DW'(0));
      settle();
      pop_a(DEPTH - X, "R3 return drain");
      settle();
      chk("R7 b_f2_afull_n after drain", DW'(b_f2_afull_n), DW'(1));
   endtask

   task automatic t_afull_release_overflow();
      int n;
      logic [DW-1:0] held;
      push_a(DEPTH - X - 1, 800);
      settle();
      chk("R6 a_f1_afull_n at DEPTH-X-1", DW'(a_f1_afull_n), DW'(1));
      push_a(1, 900);
      chk("R6/R8 a_f1_afull_n at DEPTH-X", DW'(a_f1_afull_n), DW'(0));
      settle();
      // one read on B, then count clock-A edges until release
      @(negedge clk_b);
      cs_b_n = 1'b0; wr_b = 1'b0; mbox_b = 1'b0; en_b = 1'b1;
      @(posedge clk_b);
      #1;
      idle_b();
      chk("R2 single read word", dout_b, q1.pop_front());
      n = 0;
      while (1) begin
         @(posedge clk_a);
         #1;
         n++;
         if (a_f1_afull_n || n == 6) break;
      end
      chk("R9 release edge count on clock A", DW'(n), DW'(2));
      // fill and overflow by two
      push_a(X + 3, 1000);
      settle();
      chk("R10 a_f1_afull_n when full", DW'(a_f1_afull_n), DW'(0));
      chk("R10 model depth", DW'(q1.size()), DW'(DEPTH));
      pop_b(DEPTH, "R10 stored words intact");
      settle();
      // underflow
      held = dout_b;
      @(negedge clk_b);
      cs_b_n = 1'b0; wr_b = 1'b0; mbox_b = 1'b0; en_b = 1'b1;
      repeat (2) @(negedge clk_b);
      idle_b();
      chk("R11 dout_b held on empty read", dout_b, held);
      chk("R11 b_f1_aempty_n empty", DW'(b_f1_aempty_n), DW'(0));
      push_a(1, 1100);
      settle();
      pop_b(1, "R11 read position unmoved");
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk_b);
      rst_a_n = 1'b1;
      rst_b_n = 1'b1;
      @(negedge clk_a);
      t_reset();
      t_fwd_basic();
      t_ret_basic();
      t_stream();
      t_decode();
      t_aempty();
      t_afull_b();
      t_afull_release_overflow();
      finish_run();
   end

endmodule